// File: doc/BRIEF.md
# SPI-UART Host Polling Sequencer

This block is the host-side controller for a serial-port device that is reached through 16-bit SPI frames. It turns pending requests into a fixed sequence of frames. The requests are a configuration change, an RTS level change, a priority control character, a stream of transmit bytes, a periodic poll tick and a device interrupt. Each frame goes out through a simple request/done handshake to an SPI master, which lies outside this block. The block examines each reply for a received character and for the CTS level. It forwards each character over a one-cycle hand-off, flagged with framing and parity errors.

Parity is handled by the host. For an outgoing character the block places the parity bit in frame bit 8. For an incoming character it checks bit 8 against the data. Seven-bit word length masks the top data bit on both paths. A service pass keeps repeating while the device reports more received data or while transmit data is waiting, and a stop input ends the repetition. Every transfer is serialised: a new frame never leaves while another is in flight.

Frame layout used throughout: bit 15 is the write flag and bit 14 selects configuration (1) or data (0). In a data-write frame, bit 10 disables transmission, bit 9 carries RTS, bit 8 carries parity and bits 7..0 carry the character. In a reply, bit 15 is receive-ready, bit 14 is transmit-empty, bit 10 is framing error, bit 9 is CTS, bit 8 is the received parity bit and bits 7..0 are the data.

Top module: `spu_host_seq`

## Requirements
- R1: After reset `xfer_req`, `tx_ready`, `rx_valid`, `cts` and `cts_change` are all low.
- R2: A pass sends, in this order, a pending configuration frame {2'b11, cfg_word}, then a pending RTS frame (0x8400 with bit 9 = new RTS level), then a read frame 0x0000. An RTS request with an unchanged level creates no RTS frame.
- R3: A character frame follows a read only when that read's reply has bit 14 set and a character is available; a pending priority control character is sent before any stream byte.
- R4: A character frame is 0x8000 with bit 9 = RTS level, bits 7..0 = the byte (bit 7 forced to 0 in seven-bit mode) and bit 8 = par_odd XOR the parity of the 7 or 8 data bits when par_en is high, else 0.
- R5: A reply with bit 15 set gives `rx_valid` with the data (masked to 7 bits in seven-bit mode); if reply bit 10 is set, `rx_frame_err` is high and `rx_parity_err` is low.
- R6: With par_en high and no framing error, `rx_parity_err` is high exactly when reply bit 8 differs from par_odd XOR the parity of the received data bits.
- R7: After a read or character frame, another pass starts if the last reply had bit 15 set or a character is waiting; while `stop_req` is high no further pass begins.
- R8: Replies to RTS, read and character frames are all decoded for received data and for CTS (bit 9); `cts` follows it and `cts_change` pulses one cycle when it changes.
- R9: A shutdown request sends the single frame 0xD000 (configuration write with only payload bit 12 set), even while `stop_req` is high.
- R10: A poll tick or a device interrupt pulse starts a pass consisting of a read frame.
- R11: `tx_ready` is high only in the cycle in which the character frame carrying `tx_data` is launched, and never while a transfer is in flight.
- R12: With `rx_en` low, received characters are not forwarded, but the service loop still repeats on receive-ready.
- R13: `xfer_req` and `xfer_tx` stay stable until `xfer_done`, and `xfer_req` drops in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Pulse: latch a configuration write |
| cfg_word | input | 14 | Configuration payload |
| rts_req | input | 1 | Pulse: request an RTS level |
| rts_level | input | 1 | Requested RTS level |
| par_en | input | 1 | Host parity enabled |
| par_odd | input | 1 | Odd parity selected |
| seven_bit | input | 1 | Seven-bit word length |
| rx_en | input | 1 | Forward received characters |
| poll_tick | input | 1 | Periodic poll pulse |
| dev_irq | input | 1 | Device interrupt pulse |
| stop_req | input | 1 | Stop repeating passes |
| shdn_req | input | 1 | Pulse: send shutdown frame |
| tx_valid | input | 1 | Stream byte available |
| tx_data | input | 8 | Stream byte |
| tx_ready | output | 1 | Stream byte taken this cycle |
| xchar_req | input | 1 | Pulse: latch priority control character |
| xchar_data | input | 8 | Priority control character |
| xfer_req | output | 1 | Transfer request to SPI master |
| xfer_tx | output | 16 | Frame to send |
| xfer_done | input | 1 | Transfer complete pulse |
| xfer_rx | input | 16 | Reply frame, valid with xfer_done |
| rx_valid | output | 1 | Received character pulse |
| rx_data | output | 8 | Received character |
| rx_frame_err | output | 1 | Framing error on character |
| rx_parity_err | output | 1 | Parity error on character |
| cts | output | 1 | Last seen CTS level |
| cts_change | output | 1 | CTS changed pulse |

## Verification
The assertions assume that the SPI master pulses `xfer_done` for one cycle only while `xfer_req` is high, and that the parity and word-length inputs change only while no character frame is being built. The bench's SPI model answers each request after a short random delay and pulses done exactly once. All mode changes happen between quiet periods, so both assumptions always hold. A T=0 reply with a waiting byte makes the loop run without end, so the bench ends that case with `stop_req` before the byte can drain.

// File: rtl/spu_pkg.sv
package spu_pkg;
    localparam int FRAME_W = 16;
    localparam int DATA_W  = 8;
    localparam int CONF_W  = FRAME_W - 2;

    // frame bit positions (device decodes these)
    localparam int B_WRITE = 15;
    localparam int B_CONF  = 14;
    localparam int B_RXRDY = 15;
    localparam int B_TXEMP = 14;
    localparam int B_SHDN  = 12;
    localparam int B_TXDIS = 10;
    localparam int B_FERR  = 10;
    localparam int B_RTS   = 9;
    localparam int B_CTS   = 9;
    localparam int B_PAR   = 8;

    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_EVAL} phase_e;
    typedef enum logic [2:0] {FR_CFG, FR_RTS, FR_RD, FR_TX, FR_SHDN} frame_e;
endpackage

// File: rtl/spu_parity.sv
module spu_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              short_word,
    input  logic              odd,
    output logic              par
);
    logic [DATA_W-1:0] keep;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i == DATA_W - 1) begin : g_top
            assign keep[i] = data[i] & ~short_word;
        end else begin : g_low
            assign keep[i] = data[i];
        end
    end

    assign par = odd ^ (^keep);
endmodule

// File: rtl/spu_reply_dec.sv
module spu_reply_dec
    import spu_pkg::*;
(
    input  logic [FRAME_W-1:0] reply,
    input  logic               short_word,
    input  logic               par_en,
    input  logic               par_odd,
    output logic               rx_rdy,
    output logic               tx_empty,
    output logic               cts_bit,
    output logic [DATA_W-1:0]  ch,
    output logic               frame_err,
    output logic               parity_err
);
    logic exp_par;
    logic unused_bits;

    assign unused_bits = ^reply[13:11];
    assign rx_rdy      = reply[B_RXRDY];
    assign tx_empty    = reply[B_TXEMP];
    assign cts_bit     = reply[B_CTS];
    assign ch          = reply[DATA_W-1:0] & {~short_word, {(DATA_W-1){1'b1}}};
    assign frame_err   = reply[B_FERR];

    spu_parity #(.DATA_W(DATA_W)) u_chk (
        .data       (ch),
        .short_word (short_word),
        .odd        (par_odd),
        .par        (exp_par)
    );

    // framing error suppresses the parity check
    assign parity_err = par_en & ~frame_err & (exp_par != reply[B_PAR]);
endmodule

// File: rtl/spu_frame_fmt.sv
module spu_frame_fmt
    import spu_pkg::*;
(
    input  logic [CONF_W-1:0]  cfg_w,
    input  logic               rts_lvl,
    input  logic [DATA_W-1:0]  tx_ch,
    input  logic               tx_par,
    input  logic               par_en,
    output logic [FRAME_W-1:0] f_cfg,
    output logic [FRAME_W-1:0] f_rts,
    output logic [FRAME_W-1:0] f_rd,
    output logic [FRAME_W-1:0] f_tx,
    output logic [FRAME_W-1:0] f_shdn
);
    always_comb begin
        f_cfg            = {2'b11, cfg_w};

        f_rts            = '0;
        f_rts[B_WRITE]   = 1'b1;
        f_rts[B_TXDIS]   = 1'b1;
        f_rts[B_RTS]     = rts_lvl;

        f_rd             = '0;

        f_tx             = '0;
        f_tx[B_WRITE]    = 1'b1;
        f_tx[B_RTS]      = rts_lvl;
        f_tx[B_PAR]      = par_en & tx_par;
        f_tx[DATA_W-1:0] = tx_ch;

        f_shdn           = '0;
        f_shdn[B_WRITE]  = 1'b1;
        f_shdn[B_CONF]   = 1'b1;
        f_shdn[B_SHDN]   = 1'b1;
    end
endmodule

// File: rtl/spu_host_seq.sv
module spu_host_seq
    import spu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_req,
    input  logic [CONF_W-1:0]   cfg_word,
    input  logic                rts_req,
    input  logic                rts_level,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                seven_bit,
    input  logic                rx_en,
    input  logic                poll_tick,
    input  logic                dev_irq,
    input  logic                stop_req,
    input  logic                shdn_req,
    input  logic                tx_valid,
    input  logic [DATA_W-1:0]   tx_data,
    output logic                tx_ready,
    input  logic                xchar_req,
    input  logic [DATA_W-1:0]   xchar_data,
    output logic                xfer_req,
    output logic [FRAME_W-1:0]  xfer_tx,
    input  logic                xfer_done,
    input  logic [FRAME_W-1:0]  xfer_rx,
    output logic                rx_valid,
    output logic [DATA_W-1:0]   rx_data,
    output logic                rx_frame_err,
    output logic                rx_parity_err,
    output logic                cts,
    output logic                cts_change
);
    typedef struct packed {
        phase_e              ph;
        frame_e              fr;
        logic                req;
        logic [FRAME_W-1:0]  tx_frame;
        logic [FRAME_W-1:0]  reply;
        logic                cfg_p;
        logic [CONF_W-1:0]   cfg_w;
        logic                rts_p;
        logic                rts_lvl;
        logic                x_p;
        logic [DATA_W-1:0]   x_ch;
        logic                kick_p;
        logic                shdn_p;
        logic                rxv;
        logic [DATA_W-1:0]   rxd;
        logic                fe;
        logic                pe;
        logic                cts;
        logic                cts_chg;
    } seq_t;

    seq_t q, d;

    logic [DATA_W-1:0]  tx_sel, tx_ch;
    logic               tx_par;
    logic [FRAME_W-1:0] f_cfg, f_rts, f_rd, f_tx, f_shdn;
    logic               dec_rx_rdy, dec_tx_empty, dec_cts, dec_fe, dec_pe;
    logic [DATA_W-1:0]  dec_ch;
    logic               go, pass, loop_go;
    frame_e             go_fr, first_fr;

    // priority control character wins the byte slot
    assign tx_sel = q.x_p ? q.x_ch : tx_data;
    assign tx_ch  = tx_sel & {~seven_bit, {(DATA_W-1){1'b1}}};

    spu_parity #(.DATA_W(DATA_W)) u_txpar (
        .data       (tx_ch),
        .short_word (seven_bit),
        .odd        (par_odd),
        .par        (tx_par)
    );

    spu_frame_fmt u_fmt (
        .cfg_w   (q.cfg_w),
        .rts_lvl (q.rts_lvl),
        .tx_ch   (tx_ch),
        .tx_par  (tx_par),
        .par_en  (par_en),
        .f_cfg   (f_cfg),
        .f_rts   (f_rts),
        .f_rd    (f_rd),
        .f_tx    (f_tx),
        .f_shdn  (f_shdn)
    );

    spu_reply_dec u_dec (
        .reply      (q.reply),
        .short_word (seven_bit),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .rx_rdy     (dec_rx_rdy),
        .tx_empty   (dec_tx_empty),
        .cts_bit    (dec_cts),
        .ch         (dec_ch),
        .frame_err  (dec_fe),
        .parity_err (dec_pe)
    );

    always_comb begin
        d          = q;
        d.rxv      = 1'b0;
        d.cts_chg  = 1'b0;
        tx_ready   = 1'b0;
        go         = 1'b0;
        pass       = 1'b0;
        go_fr      = FR_RD;
        first_fr   = q.cfg_p ? FR_CFG : (q.rts_p ? FR_RTS : FR_RD);
        loop_go    = !stop_req && (dec_rx_rdy || q.x_p || tx_valid);

        unique case (q.ph)
            PH_IDLE: begin
                if (q.shdn_p) begin
                    go    = 1'b1;
                    go_fr = FR_SHDN;
                end else if (!stop_req &&
                             (q.kick_p || q.cfg_p || q.rts_p || q.x_p || tx_valid)) begin
                    go    = 1'b1;
                    go_fr = first_fr;
                    pass  = 1'b1;
                end
            end
            PH_WAIT: begin
                if (xfer_done) begin
                    d.reply = xfer_rx;
                    d.req   = 1'b0;
                    d.ph    = PH_EVAL;
                end
            end
            PH_EVAL: begin
                d.ph = PH_IDLE;
                if (q.fr == FR_RTS || q.fr == FR_RD || q.fr == FR_TX) begin
                    if (dec_rx_rdy && rx_en) begin
                        d.rxv = 1'b1;
                        d.rxd = dec_ch;
                        d.fe  = dec_fe;
                        d.pe  = dec_pe;
                    end
                    if (dec_cts != q.cts) begin
                        d.cts     = dec_cts;
                        d.cts_chg = 1'b1;
                    end
                end
                unique case (q.fr)
                    FR_CFG: begin
                        go    = 1'b1;
                        go_fr = q.rts_p ? FR_RTS : FR_RD;
                    end
                    FR_RTS: begin
                        go    = 1'b1;
                        go_fr = FR_RD;
                    end
                    FR_RD: begin
                        if (dec_tx_empty && (q.x_p || tx_valid)) begin
                            go       = 1'b1;
                            go_fr    = FR_TX;
                            tx_ready = !q.x_p;
                        end else if (loop_go) begin
                            go    = 1'b1;
                            go_fr = first_fr;
                            pass  = 1'b1;
                        end
                    end
                    FR_TX: begin
                        if (loop_go) begin
                            go    = 1'b1;
                            go_fr = first_fr;
                            pass  = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            default: d.ph = PH_IDLE;
        endcase

        if (go) begin
            d.ph  = PH_WAIT;
            d.req = 1'b1;
            d.fr  = go_fr;
            unique case (go_fr)
                FR_CFG:  begin d.tx_frame = f_cfg;  d.cfg_p  = 1'b0; end
                FR_RTS:  begin d.tx_frame = f_rts;  d.rts_p  = 1'b0; end
                FR_TX:   begin d.tx_frame = f_tx;   d.x_p    = 1'b0; end
                FR_SHDN: begin d.tx_frame = f_shdn; d.shdn_p = 1'b0; end
                default: d.tx_frame = f_rd;
            endcase
        end
        if (pass) d.kick_p = 1'b0;

        // new requests are latched after the clears so none is lost
        if (poll_tick || dev_irq) d.kick_p = 1'b1;
        if (cfg_req) begin
            d.cfg_p = 1'b1;
            d.cfg_w = cfg_word;
        end
        if (rts_req && (rts_level != q.rts_lvl)) begin
            d.rts_lvl = rts_level;
            d.rts_p   = 1'b1;
        end
        if (xchar_req) begin
            d.x_p  = 1'b1;
            d.x_ch = xchar_data;
        end
        if (shdn_req) d.shdn_p = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign xfer_req      = q.req;
    assign xfer_tx       = q.tx_frame;
    assign rx_valid      = q.rxv;
    assign rx_data       = q.rxd;
    assign rx_frame_err  = q.fe;
    assign rx_parity_err = q.pe;
    assign cts           = q.cts;
    assign cts_change    = q.cts_chg;
endmodule

// File: rtl/spu_host_seq_chk.sv
module spu_host_seq_chk
    import spu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [DATA_W-1:0]  tx_data,
    input logic               seven_bit,
    input logic               par_en,
    input logic               par_odd,
    input logic               rx_en,
    input logic               xfer_req,
    input logic [FRAME_W-1:0] xfer_tx,
    input logic               xfer_done,
    input logic               rx_valid,
    input logic               rx_frame_err,
    input logic               rx_parity_err,
    input logic               cts,
    input logic               cts_change
);
    // R11
    tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_valid) |=> (xfer_req && xfer_tx[15:14] == 2'b10 &&
                                    xfer_tx[6:0] == $past(tx_data[6:0])));

    // R11
    tx_ready_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !xfer_req);

    // R13
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));

    // R13
    xfer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_req);

    // R4
    tx_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xfer_req) && xfer_tx[15:14] == 2'b10 && !xfer_tx[10] && $past(par_en))
        |-> (xfer_tx[8] == ($past(par_odd) ^ (^xfer_tx[6:0]) ^
                            (xfer_tx[7] & !$past(seven_bit)))));

    // R4
    tx_short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xfer_req) && xfer_tx[15:14] == 2'b10 && !xfer_tx[10] && $past(seven_bit))
        |-> !xfer_tx[7]);

    // R5
    err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !(rx_frame_err && rx_parity_err));

    // R12
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_en));

    // R8
    cts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cts_change |-> (cts != $past(cts)));
endmodule

bind spu_host_seq spu_host_seq_chk u_chk (.*);

// File: tb/spu_host_seq_tb.sv
`timescale 1ns/1ps
module spu_host_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 0, rts_req = 0, rts_level = 0;
    logic [13:0] cfg_word = '0;
    logic        par_en = 0, par_odd = 0, seven_bit = 0, rx_en = 1;
    logic        poll_tick = 0, dev_irq = 0, stop_req = 0, shdn_req = 0;
    logic        tx_valid = 0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready;
    logic        xchar_req = 0;
    logic [7:0]  xchar_data = '0;
    logic        xfer_req;
    logic [15:0] xfer_tx;
    logic        xfer_done = 0;
    logic [15:0] xfer_rx = '0;
    logic        rx_valid, rx_frame_err, rx_parity_err, cts, cts_change;
    logic [7:0]  rx_data;

    always #2 clk = ~clk;

    spu_host_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_word(cfg_word),
        .rts_req(rts_req), .rts_level(rts_level), .par_en(par_en),
        .par_odd(par_odd), .seven_bit(seven_bit), .rx_en(rx_en),
        .poll_tick(poll_tick), .dev_irq(dev_irq), .stop_req(stop_req),
        .shdn_req(shdn_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .xchar_req(xchar_req), .xchar_data(xchar_data),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
        .xfer_rx(xfer_rx), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .cts(cts), .cts_change(cts_change)
    );

    int n_chk = 0, n_fail = 0;
    logic [15:0] reply_q [0:63];
    int rp_wr = 0, rp_rd = 0;
    logic [15:0] dflt = 16'h4000;
    logic [15:0] fr_log [0:255];
    int fr_n = 0;
    logic [9:0] rx_log [0:63];
    int rx_n = 0;
    int cts_chg_n = 0;
    int m_busy = 0, m_cnt = 0;
    logic b_rts = 0;
    bit finished = 0;

    // SPI master model
    always @(negedge clk) begin
        if (xfer_done) begin
            xfer_done = 1'b0;
        end else if (m_busy != 0) begin
            if (m_cnt == 0) begin
                if (rp_rd < rp_wr) begin
                    xfer_rx = reply_q[rp_rd];
                    rp_rd = rp_rd + 1;
                end else begin
                    xfer_rx = dflt;
                end
                xfer_done = 1'b1;
                m_busy = 0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end else if (rst_n && xfer_req) begin
            if (fr_n < 256) fr_log[fr_n] = xfer_tx;
            fr_n = fr_n + 1;
            m_busy = 1;
            m_cnt = int'($urandom_range(0, 3));
        end
    end

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_n < 64) rx_log[rx_n] = {rx_frame_err, rx_parity_err, rx_data};
            rx_n = rx_n + 1;
        end
        if (rst_n && cts_change) cts_chg_n = cts_chg_n + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic ep(input logic [7:0] dd, input logic sev, input logic odd);
        logic [7:0] m;
        m = sev ? (dd & 8'h7F) : dd;
        return odd ^ (^m);
    endfunction

    function automatic logic [15:0] exp_tx(input logic [7:0] dd, input logic rts,
                                           input logic pen, input logic odd, input logic sev);
        logic [15:0] f;
        f = 16'h8000;
        f[9] = rts;
        f[8] = pen & ep(dd, sev, odd);
        f[7:0] = sev ? (dd & 8'h7F) : dd;
        return f;
    endfunction

    task automatic clear_logs();
        fr_n = 0; rx_n = 0; rp_wr = 0; rp_rd = 0;
    endtask

    task automatic push_reply(input logic [15:0] r);
        reply_q[rp_wr] = r;
        rp_wr = rp_wr + 1;
    endtask

    task automatic wait_quiet();
        int qc = 0;
        while (qc < 12) begin
            @(negedge clk);
            if (!xfer_req && m_busy == 0 && !xfer_done) qc++;
            else qc = 0;
        end
    endtask

    task automatic take_byte();
        do @(negedge clk); while (!tx_ready);
        @(posedge clk);
        #1;
        chk(xfer_req && xfer_tx[6:0] == tx_data[6:0], "R11 accept launches frame",
            {16'h0, xfer_tx}, {24'h0, tx_data});
        tx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] dd);
        @(negedge clk);
        tx_data = dd;
        tx_valid = 1'b1;
        take_byte();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] dd;
        logic pen, odd, sev, fe, bad;
        logic [15:0] r;
        int base;
        bit any_tx;
        void'($urandom(32'd7));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!xfer_req && !tx_ready && !rx_valid && !cts && !cts_change, "R1 reset state",
            {27'h0, xfer_req, tx_ready, rx_valid, cts, cts_change}, 32'h0);

        // R10 poll tick
        dflt = 16'h0000; clear_logs();
        @(negedge clk) poll_tick = 1; @(negedge clk) poll_tick = 0;
        wait_quiet();
        chk(fr_n == 1 && fr_log[0] == 16'h0000, "R10 poll tick read", fr_n, 1);
        // R10 interrupt
        clear_logs();
        @(negedge clk) dev_irq = 1; @(negedge clk) dev_irq = 0;
        wait_quiet();
        chk(fr_n == 1 && fr_log[0] == 16'h0000, "R10 irq read", fr_n, 1);

        // R2 ordering
        clear_logs();
        @(negedge clk) begin cfg_req = 1; cfg_word = 14'h0A5C; rts_req = 1; rts_level = 1; end
        @(negedge clk) begin cfg_req = 0; rts_req = 0; end
        b_rts = 1;
        wait_quiet();
        chk(fr_n == 3, "R2 frame count", fr_n, 3);
        chk(fr_log[0] == 16'hCA5C, "R2 config first", fr_log[0], 16'hCA5C);
        chk(fr_log[1] == 16'h8600, "R2 rts second", fr_log[1], 16'h8600);
        chk(fr_log[2] == 16'h0000, "R2 read third", fr_log[2], 16'h0000);
        // R2 unchanged RTS level gives no RTS frame
        clear_logs();
        @(negedge clk) begin rts_req = 1; rts_level = 1; poll_tick = 1; end
        @(negedge clk) begin rts_req = 0; poll_tick = 0; end
        wait_quiet();
        chk(fr_n == 1 && fr_log[0] == 16'h0000, "R2 same rts no frame", fr_n, 1);

        // R4 random transmit
        dflt = 16'h4000;
        for (int i = 0; i < 24; i++) begin
            dd = 8'($urandom); pen = 1'($urandom); odd = 1'($urandom); sev = 1'($urandom);
            if (i == 0) begin dd = 8'hFF; pen = 1; odd = 0; sev = 1; end
            @(negedge clk) begin par_en = pen; par_odd = odd; seven_bit = sev; end
            clear_logs();
            send_byte(dd);
            wait_quiet();
            chk(fr_n == 2 && fr_log[0] == 16'h0000, "R3 read before tx", fr_n, 2);
            chk(fr_log[1] == exp_tx(dd, b_rts, pen, odd, sev), "R4 tx frame",
                fr_log[1], exp_tx(dd, b_rts, pen, odd, sev));
        end
        chk(exp_tx(8'hFF, 1, 1, 0, 1) == 16'h837F, "R4 seven-bit directed", exp_tx(8'hFF, 1, 1, 0, 1), 16'h837F);

        // R3 priority character first
        @(negedge clk) begin par_en = 0; seven_bit = 0; end
        clear_logs();
        @(negedge clk) begin xchar_req = 1; xchar_data = 8'h13; tx_valid = 1; tx_data = 8'h41; end
        @(negedge clk) xchar_req = 0;
        take_byte();
        wait_quiet();
        chk(fr_n == 4, "R3 priority frame count", fr_n, 4);
        chk(fr_log[1] == 16'h8213, "R3 priority first", fr_log[1], 16'h8213);
        chk(fr_log[3] == 16'h8241, "R3 stream after", fr_log[3], 16'h8241);

        // R3/R7 not empty: loop polls, no tx; stop ends it
        dflt = 16'h0000; clear_logs();
        @(negedge clk) begin tx_valid = 1; tx_data = 8'h22; end
        repeat (40) @(negedge clk);
        stop_req = 1;
        wait_quiet();
        any_tx = 0;
        for (int k = 0; k < fr_n && k < 256; k++) if (fr_log[k][15]) any_tx = 1;
        chk(!any_tx, "R3 no tx without empty flag", any_tx, 0);
        chk(fr_n >= 3, "R7 loop repeats on pending data", fr_n, 3);
        clear_logs();
        repeat (30) @(negedge clk);
        chk(fr_n == 0, "R7 stop blocks new pass", fr_n, 0);
        dflt = 16'h4000;
        stop_req = 0;
        take_byte();
        wait_quiet();
        chk(fr_n >= 2 && fr_log[fr_n-1] == 16'h8222, "R3 tx once empty", fr_log[fr_n-1], 16'h8222);

        // R5/R6 receive
        dflt = 16'h0000;
        for (int i = 0; i < 16; i++) begin
            dd = 8'($urandom); pen = 1'($urandom); odd = 1'($urandom); sev = 1'($urandom);
            fe = ($urandom_range(0, 3) == 0); bad = 1'($urandom);
            if (i == 0) begin pen = 1; fe = 1; bad = 1; end
            @(negedge clk) begin par_en = pen; par_odd = odd; seven_bit = sev; end
            clear_logs();
            r = 16'h8000 | (16'(fe) << 10) | (16'(ep(dd, sev, odd) ^ bad) << 8) | 16'(dd);
            push_reply(r);
            @(negedge clk) poll_tick = 1; @(negedge clk) poll_tick = 0;
            wait_quiet();
            chk(fr_n == 2, "R7 repeat after receive-ready", fr_n, 2);
            chk(rx_n == 1 && rx_log[0] == {fe, pen & ~fe & bad, (sev ? (dd & 8'h7F) : dd)},
                "R5 R6 received char", {22'h0, rx_log[0]}, {22'h0, fe, pen & ~fe & bad, (sev ? (dd & 8'h7F) : dd)});
        end

        // R8 rx and CTS on RTS reply
        @(negedge clk) begin par_en = 0; seven_bit = 0; end
        clear_logs();
        base = cts_chg_n;
        push_reply(16'h8233);
        push_reply(16'h0200);
        dflt = 16'h0200;
        @(negedge clk) begin rts_req = 1; rts_level = 0; end
        @(negedge clk) rts_req = 0;
        b_rts = 0;
        wait_quiet();
        chk(fr_n == 2 && fr_log[0] == 16'h8400, "R8 rts frame", fr_log[0], 16'h8400);
        chk(rx_n == 1 && rx_log[0] == 10'h033, "R8 rx from write reply", {22'h0, rx_log[0]}, 32'h33);
        chk(cts == 1'b1 && cts_chg_n == base + 1, "R8 cts tracked", cts_chg_n - base, 1);

        // R12 rx disabled
        clear_logs();
        push_reply(16'h825A);
        @(negedge clk) begin rx_en = 0; poll_tick = 1; end
        @(negedge clk) poll_tick = 0;
        wait_quiet();
        chk(rx_n == 0, "R12 no forward when disabled", rx_n, 0);
        chk(fr_n == 2, "R12 loop still repeats", fr_n, 2);
        rx_en = 1;

        // R9 shutdown, even under stop
        clear_logs();
        @(negedge clk) begin stop_req = 1; shdn_req = 1; end
        @(negedge clk) shdn_req = 0;
        wait_quiet();
        chk(fr_n == 1 && fr_log[0] == 16'hD000, "R9 shutdown frame", fr_log[0], 16'hD000);
        stop_req = 0;

        // R8 cts falls back
        clear_logs();
        base = cts_chg_n;
        dflt = 16'h0000;
        @(negedge clk) poll_tick = 1; @(negedge clk) poll_tick = 0;
        wait_quiet();
        chk(cts == 1'b0 && cts_chg_n == base + 1, "R8 cts falls", cts_chg_n - base, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule